// File: doc/BRIEF.md
# Clocked Controller for a 32K x 8 Asynchronous Static RAM

This block sits between a synchronous host and an asynchronous byte-wide static RAM with active-low chip, write and output enables. The host offers one access at a time: a 15-bit byte address, a direction flag and, for stores, a data byte. The controller turns each request into a timed sequence of strobes on the memory pins. Each timing minimum of the RAM is given in nanoseconds as a parameter. It is converted to a whole number of clock cycles by rounding up, with a floor of one cycle.

The shared data bus is split at this boundary into an outgoing byte, an incoming byte and a drive-enable. The pad that joins them lives outside the block. The controller raises the drive-enable only inside the write strobe. Before that it holds the RAM's output enable high for the worst-case release time of the RAM's drivers.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip enable, write enable and output enable are all high, the data drive-enable is low, and `host_rdy` is high.
- R2: A store holds write enable low for exactly N_WR = ceil(max(50, 70, 70, 40) ns / CLK_NS) cycles, which is 14 at 5 ns. Chip enable is low throughout and output enable stays high.
- R3: The data drive-enable is high exactly in the cycles where write enable is low. It is never high while output enable is low.
- R4: Before write enable falls, the store spends exactly N_HZ = ceil(35 ns / CLK_NS) cycles (7 at 5 ns) with chip enable low, write and output enables high, and the bus not driven.
- R5: The RAM address and the outgoing data byte change only on the clock edge that accepts a request. They stay constant while chip enable is low.
- R6: A load holds chip enable and output enable low, with write enable high, for exactly N_RD = ceil(max(70, 50) ns / CLK_NS) cycles (14 at 5 ns). The incoming byte is captured on the last clock edge of that window.
- R7: `rd_valid` is high for exactly one cycle, the cycle right after a load's window ends, with the captured byte on `rd_data`. A store never raises it.
- R8: A request is accepted only on an edge where `req` and `host_rdy` are both high. Between two accesses every strobe is high for at least one cycle.
- R9: A byte stored at an address is returned by every later load of that address until it is overwritten. This holds across the whole 15-bit address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until accepted |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to store |
| host_rdy | output | 1 | Controller idle; a request is accepted on this edge |
| rd_data | output | 8 | Byte returned by the last load |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| sram_addr | output | 15 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | 8 | Byte driven toward the RAM |
| sram_dq_oe | output | 1 | Drive-enable for sram_dq_out |
| sram_dq_in | input | 8 | Byte received from the RAM |

## Verification
The assertions check the following on every cycle:
- the length of each write strobe;
- that the drive-enable appears only after a long enough release window;
- that the address is frozen under a low write enable;
- that the strobes are idle whenever the host sees ready;
- the single-cycle shape of `rd_valid`.

Other properties need the bench's scenarios to show them:
- that loaded bytes match earlier stores at the edges of the address range and after overwrites;
- that the capture edge is not early, which the bench's RAM model exposes by returning wrong data until the access window has elapsed;
- that stores never produce a `rd_valid`.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WHZ    = 2'd1,
    ST_WPULSE = 2'd2,
    ST_READ   = 2'd3
  } st_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctl_pkg::*;
(
  input  st_e  st,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    unique case (st)
      ST_IDLE:   ;
      ST_WHZ:    ce_n = 1'b0;
      ST_WPULSE: begin ce_n = 1'b0; we_n = 1'b0; dq_oe = 1'b1; end
      ST_READ:   begin ce_n = 1'b0; oe_n = 1'b0; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS  = 5,
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int T_WP_NS = 50,
  parameter int T_CW_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_DW_NS = 40,
  parameter int T_RC_NS = 70,
  parameter int T_OE_NS = 50,
  parameter int T_HZ_NS = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          host_rdy,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  localparam int N_HZ  = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int N_WR  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                              imax(ns2cyc(T_WC_NS, CLK_NS), ns2cyc(T_DW_NS, CLK_NS)));
  localparam int N_RD  = imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
  localparam int N_MAX = imax(imax(N_HZ, N_WR), N_RD);
  localparam int CW    = $clog2(N_MAX + 1);

  st_e           st, st_nxt;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          phase_done;
  logic          accept;
  logic          rd_capture;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  assign accept = req && (st == ST_IDLE);

  sram_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(phase_done)
  );

  sram_pin_decode u_pins (
    .st(st), .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n), .dq_oe(sram_dq_oe)
  );

  always_comb begin
    st_nxt     = st;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rd_capture = 1'b0;
    unique case (st)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_wr) begin st_nxt = ST_WHZ;  tmr_val = CW'(N_HZ - 1); end
        else        begin st_nxt = ST_READ; tmr_val = CW'(N_RD - 1); end
      end
      ST_WHZ: if (phase_done) begin
        st_nxt = ST_WPULSE; tmr_load = 1'b1; tmr_val = CW'(N_WR - 1);
      end
      ST_WPULSE: if (phase_done) st_nxt = ST_IDLE;
      ST_READ: if (phase_done) begin
        st_nxt = ST_IDLE; rd_capture = 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      a_q      <= '0;
      d_q      <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      st       <= st_nxt;
      rd_valid <= rd_capture;
      if (accept) begin
        a_q <= req_addr;
        d_q <= req_wdata;
      end
      if (rd_capture) rd_data <= sram_dq_in;
    end
  end

  assign host_rdy    = (st == ST_IDLE);
  assign sram_addr   = a_q;
  assign sram_dq_out = d_q;

  // ---------------- checks ----------------
  logic [CW-1:0] oe_hi_cnt, we_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      if (!sram_oe_n)                     oe_hi_cnt <= '0;
      else if (oe_hi_cnt != CW'(N_MAX))   oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (sram_we_n)                      we_lo_cnt <= '0;
      else if (we_lo_cnt != CW'(N_MAX))   we_lo_cnt <= we_lo_cnt + 1'b1;
    end
  end

  // R2
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> we_lo_cnt == CW'(N_WR));
  // R4
  release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> oe_hi_cnt >= CW'(N_HZ));
  // R5
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));
  // R8
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R6
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!sram_oe_n && !sram_ce_n));
  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int AW = 15;
  localparam int DW = 8;
  // expected phase lengths at a 5 ns clock, from the requirements
  localparam int EXP_HZ = (35 + 4) / 5;
  localparam int EXP_WR = (70 + 4) / 5;
  localparam int EXP_RD = (70 + 4) / 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic host_rdy, rd_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rd_data, sram_dq_out;
  logic [DW-1:0] sram_dq_in = '0;
  logic [AW-1:0] sram_addr;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] ram [int];
  logic [DW-1:0] gold [int];
  logic [DW-1:0] exp_q [$];
  int rd_age = 0;

  always #2.5 clk = ~clk;

  sram_ctl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .host_rdy(host_rdy), .rd_data(rd_data), .rd_valid(rd_valid),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // RAM model: stores on write-enable low, returns wrong bytes until the access time elapses
  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) ram[int'(sram_addr)] = sram_dq_out;
    if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_age <= rd_age + 1;
    else rd_age <= 0;
  end
  always @(negedge clk) begin
    logic [DW-1:0] v;
    v = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : '0;
    sram_dq_in = (rd_age >= EXP_RD - 1) ? v : ~v;
  end

  // pin-timing monitor
  int we_run = 0, oe_run = 0, hz_run = 0;
  bit addr_moved = 0;
  logic [AW-1:0] a_seen;
  logic [DW-1:0] d_seen;
  logic p_we = 1, p_oe = 1, p_ce = 1;
  int v_run = 0;
  always @(negedge clk) if (rst_n) begin
    if (!sram_ce_n && p_ce) begin a_seen = sram_addr; d_seen = sram_dq_out; addr_moved = 0; end
    if (!sram_ce_n && (sram_addr !== a_seen || sram_dq_out !== d_seen)) addr_moved = 1;
    if (sram_ce_n && !p_ce) check(!addr_moved, "R5 addr/data frozen", addr_moved, 0);
    if (!sram_we_n) begin
      we_run++;
      if (p_we) check(hz_run == EXP_HZ, "R4 release wait", hz_run, EXP_HZ);
    end else if (!p_we) begin
      check(we_run == EXP_WR, "R2 write strobe width", we_run, EXP_WR);
      we_run = 0;
    end
    if (!sram_ce_n && sram_we_n && sram_oe_n) hz_run++; else if (sram_ce_n) hz_run = 0;
    if (sram_dq_oe !== !sram_we_n || (sram_dq_oe && !sram_oe_n))
      check(0, "R3 drive-enable", sram_dq_oe, !sram_we_n);
    if (!sram_we_n && (!sram_oe_n || sram_ce_n)) check(0, "R2 strobes during write", sram_oe_n, 1);
    if (!sram_oe_n) oe_run++;
    else if (!p_oe) begin
      check(oe_run == EXP_RD, "R6 read window", oe_run, EXP_RD);
      oe_run = 0;
    end
    if (host_rdy && !(sram_ce_n && sram_we_n && sram_oe_n))
      check(0, "R8 idle strobes", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    if (rd_valid) begin
      v_run++;
      if (v_run > 1) check(0, "R7 valid pulse length", v_run, 1);
      else if (exp_q.size() == 0) check(0, "R7 valid without load", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data === e, "R9 load data", rd_data, e);
      end
    end else v_run = 0;
    p_we = sram_we_n; p_oe = sram_oe_n; p_ce = sram_ce_n;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    while (!host_rdy) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    check(!host_rdy, "R8 busy after accept", host_rdy, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    gold[int'(a)] = d;
    issue(1'b1, a, d);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    exp_q.push_back(gold.exists(int'(a)) ? gold[int'(a)] : '0);
    issue(1'b0, a, '0);
  endtask

  initial begin
    #1;
    // R1 reset state
    check(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes in reset", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    check(!sram_dq_oe, "R1 drive off in reset", sram_dq_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_rdy, "R1 ready after reset", host_rdy, 1);
    check(!rd_valid, "R1 no valid after reset", rd_valid, 0);

    do_write(15'h0000, 8'h00);
    do_write(15'h7FFF, 8'hFF);
    do_write(15'h1234, 8'hA5);
    do_write(15'h4321, 8'h5A);
    do_read(15'h7FFF);
    do_read(15'h0000);
    do_read(15'h1234);
    do_read(15'h4321);
    do_write(15'h1234, 8'h3C);   // overwrite
    do_read(15'h1234);
    do_read(15'h1234);
    do_write(15'h0001, 8'h81);
    do_write(15'h0002, 8'h42);
    // R7: stores produce no valid; wait and confirm queue unchanged
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 24; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0]) do_write(lf[AW-1:0] ^ 15'h2AAA, lf[15:8]);
        else       do_read(15'h0001 << (i % AW));
      end
    end
    do_read(15'h0001);
    do_read(15'h0002);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R7 all loads returned", exp_q.size(), 0);
    check(host_rdy && sram_ce_n, "R1 idle at end", host_rdy, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule